// File: doc/BRIEF.md
# Gated NMI and Hardware Interrupt Controller

This block presents interrupts from an I/O gate array to a CPU. It has two paths. A non-maskable path is fed by one external pin and gated by an 8-bit NMI control register. A maskable path is fed by a vector of hardware request lines, and each line has its own 16-bit control register holding a vector, an enable bit and a pending bit. In every cycle in which nothing is active, the controller chooses one ready source. An enabled NMI always wins. Among hardware sources the lowest index wins. The controller then raises either `nmi_o` or `irq_o` and holds it until the CPU acknowledges.

While a source is active, `act_vec_o` shows its vector. The acknowledge pulse clears that source's pending state, and a new choice is made in the cycle that follows. Software programs the control registers through a single write port. A read index returns any hardware register. The NMI control register is always visible on its own output.

Both register kinds support a forced interrupt. Software arms the force with one write and fires it with a later write.

Top module: `gated_nmi_intc`

## Requirements
- R1: While reset is asserted, and right after it, `nmi_o` and `irq_o` are low, the NMI control register reads 0x00, and every hardware register reads 0x0000.
- R2: The NMI control bits are: bit 1 enable-A, bit 2 edge mode, bit 3 negative polarity, bit 4 enable-B. Bit 0 is stored but has no effect. An NMI is accepted only when enable-A and enable-B are both set. `nmi_o` rises two clock edges after the pin rises.
- R3: A rising pin sets the NMI pending flag and a falling pin clears it. An NMI whose pin fell before both enables were set is never taken.
- R4: When an NMI and a hardware source are both ready in the same choice cycle, the NMI is taken. The hardware source is taken after the NMI is acknowledged.
- R5: If the edge-mode bit is clear when an NMI is taken, enable-B is cleared in the control register. If the edge-mode bit is set, the register is unchanged. A control write on the taking edge overrides this clearing.
- R6: A control write that takes negative polarity from 1 to 0 sets the NMI pending flag, provided the written value has both enables set.
- R7: While an NMI is active, `act_vec_o` shows NMI_VEC (0xFF by default). An acknowledge clears the NMI pending flag, and `nmi_o` is low on the next cycle.
- R8: In a hardware register, bits 7:0 are the vector, bit 8 is pending and bit 11 is enable. A write with bit 8 set arms a force for that source. It stores every other bit and leaves the pending bit as it was.
- R9: A write with bit 8 clear to an armed source stores the data with pending set, and it disarms the force. A write with bit 8 clear to an unarmed source stores the data as written, so pending ends up clear.
- R10: A rising request line sets that source's pending bit and a falling line clears it.
- R11: A source is taken only when it is pending and enabled. The lowest such index wins. `irq_o` stays high until acknowledge, and `act_vec_o` shows the source's low byte.
- R12: Acknowledging a hardware interrupt clears its pending bit, and `irq_o` is low on the next cycle. A request rising on the same source in the acknowledge cycle keeps it pending.
- R13: Nothing new is taken while an interrupt is active and not yet acknowledged, and `nmi_o` and `irq_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_pin_i | input | 1 | External NMI pin |
| hw_req_i | input | NUM_SRC | Hardware request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the NMI control register, 1 selects a hardware register |
| wr_idx_i | input | IDX_W | Hardware register index for a write |
| wr_data_i | input | REG_W | Write data (low CTL_W bits are used for the NMI control register) |
| ack_i | input | 1 | CPU acknowledge pulse |
| rd_idx_i | input | IDX_W | Hardware register index for a read |
| nmi_o | output | 1 | NMI to the CPU |
| irq_o | output | 1 | Maskable interrupt to the CPU |
| act_vec_o | output | VEC_W | Vector of the active source |
| nmi_ctrl_o | output | CTL_W | NMI control register |
| rd_data_o | output | REG_W | Hardware register selected by rd_idx_i |

## Verification
Two pairs of events can fall on one clock edge. In the first, an NMI is taken in level mode, which clears enable-B, on the same edge as a software write to the NMI control register. The bench provokes this by latching the pin while the enables are off and then writing the enables one cycle before a second control write. The second write must survive intact, and the NMI must still be taken. In the second, a hardware acknowledge lands on the same edge as a fresh rising request on that source. The bench checks that `irq_o` drops for exactly one cycle and that the same vector is presented again.

// File: rtl/gnmi_pkg.sv
package gnmi_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_HW   = 2'd2
  } act_e;

  localparam int NC_EN_A  = 1;
  localparam int NC_EDGE  = 2;
  localparam int NC_NEG   = 3;
  localparam int NC_EN_B  = 4;
endpackage

// File: rtl/gnmi_nmi_gate.sv
module gnmi_nmi_gate #(
  parameter int CTL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             take_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic [CTL_W-1:0] ctrl_o
);
  import gnmi_pkg::*;

  logic             pin_q, pend_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             pend_d;
  logic [CTL_W-1:0] ctrl_d;
  logic             rise, fall, force_set;

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;
  // polarity written 1 -> 0 with both enables in the new value
  assign force_set = wr_en_i & ctrl_q[NC_NEG] & ~wr_data_i[NC_NEG]
                   & wr_data_i[NC_EN_A] & wr_data_i[NC_EN_B];

  always_comb begin
    pend_d = pend_q;
    if (ack_i)     pend_d = 1'b0;
    if (fall)      pend_d = 1'b0;
    if (rise)      pend_d = 1'b1;
    if (force_set) pend_d = 1'b1;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (take_i && !ctrl_q[NC_EDGE]) ctrl_d[NC_EN_B] = 1'b0;
    if (wr_en_i) ctrl_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      pin_q  <= pin_i;
      pend_q <= pend_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ready_o = pend_q & ctrl_q[NC_EN_A] & ctrl_q[NC_EN_B];
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/gnmi_src_bank.sv
module gnmi_src_bank #(
  parameter int NUM_SRC  = 16,
  parameter int REG_W    = 16,
  parameter int PEND_BIT = 8,
  parameter int EN_BIT   = 11,
  parameter int IDX_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [REG_W-1:0]              wr_data_i,
  input  logic [NUM_SRC-1:0]            ack_clr_i,
  output logic [NUM_SRC-1:0][REG_W-1:0] regs_o,
  output logic [NUM_SRC-1:0]            ready_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic             req_q, forced_q, forced_d;
    logic [REG_W-1:0] reg_q, reg_d;
    logic             sel, pend_evt;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      pend_evt = reg_q[PEND_BIT];
      if (ack_clr_i[g])        pend_evt = 1'b0;
      if (!req_i[g] && req_q)  pend_evt = 1'b0;
      if (req_i[g] && !req_q)  pend_evt = 1'b1;

      reg_d           = reg_q;
      reg_d[PEND_BIT] = pend_evt;
      forced_d        = forced_q;
      if (sel) begin
        if (wr_data_i[PEND_BIT]) begin
          forced_d        = 1'b1;
          reg_d           = wr_data_i;
          reg_d[PEND_BIT] = pend_evt;
        end else if (forced_q) begin
          forced_d        = 1'b0;
          reg_d           = wr_data_i;
          reg_d[PEND_BIT] = 1'b1;
        end else begin
          reg_d = wr_data_i;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q    <= 1'b0;
        forced_q <= 1'b0;
        reg_q    <= '0;
      end else begin
        req_q    <= req_i[g];
        forced_q <= forced_d;
        reg_q    <= reg_d;
      end
    end

    assign regs_o[g]  = reg_q;
    assign ready_o[g] = reg_q[PEND_BIT] & reg_q[EN_BIT];
  end
endmodule

// File: rtl/gnmi_pick.sv
module gnmi_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/gated_nmi_intc.sv
module gated_nmi_intc #(
  parameter int              NUM_SRC  = 16,
  parameter int              REG_W    = 16,
  parameter int              CTL_W    = 8,
  parameter int              VEC_W    = 8,
  parameter int              PEND_BIT = 8,
  parameter int              EN_BIT   = 11,
  parameter logic [VEC_W-1:0] NMI_VEC = 8'hFF,
  localparam int             IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nmi_pin_i,
  input  logic [NUM_SRC-1:0] hw_req_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               nmi_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   act_vec_o,
  output logic [CTL_W-1:0]   nmi_ctrl_o,
  output logic [REG_W-1:0]   rd_data_o
);
  import gnmi_pkg::*;

  act_e                        act_q, act_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic                        nmi_ready, nmi_take, nmi_ack;
  logic                        hw_valid, hw_ack;
  logic [IDX_W-1:0]            hw_idx;
  logic [NUM_SRC-1:0]          hw_ready, ack_clr;
  logic [NUM_SRC-1:0][REG_W-1:0] regs;

  assign nmi_ack = ack_i && (act_q == ACT_NMI);
  assign hw_ack  = ack_i && (act_q == ACT_HW);
  assign ack_clr = hw_ack ? (NUM_SRC'(1) << idx_q) : '0;
  assign nmi_take = (act_q == ACT_NONE) && nmi_ready;

  gnmi_nmi_gate #(.CTL_W(CTL_W)) u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (nmi_pin_i),
    .wr_en_i   (wr_en_i && !wr_sel_i),
    .wr_data_i (wr_data_i[CTL_W-1:0]),
    .take_i    (nmi_take),
    .ack_i     (nmi_ack),
    .ready_o   (nmi_ready),
    .ctrl_o    (nmi_ctrl_o)
  );

  gnmi_src_bank #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W),
    .PEND_BIT(PEND_BIT),
    .EN_BIT  (EN_BIT),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (hw_req_i),
    .wr_en_i   (wr_en_i && wr_sel_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ack_clr_i (ack_clr),
    .regs_o    (regs),
    .ready_o   (hw_ready)
  );

  gnmi_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i   (hw_ready),
    .valid_o (hw_valid),
    .idx_o   (hw_idx)
  );

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (act_q == ACT_NONE) begin
      if (nmi_ready) begin
        act_d = ACT_NMI;
      end else if (hw_valid) begin
        act_d = ACT_HW;
        idx_d = hw_idx;
      end
    end else if (ack_i) begin
      act_d = ACT_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= ACT_NONE;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    case (act_q)
      ACT_NMI: act_vec_o = NMI_VEC;
      ACT_HW:  act_vec_o = regs[idx_q][VEC_W-1:0];
      default: act_vec_o = '0;
    endcase
  end

  assign nmi_o     = (act_q == ACT_NMI);
  assign irq_o     = (act_q == ACT_HW);
  assign rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/gnmi_intc_chk.sv
module gnmi_intc_chk #(
  parameter int CTL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic             ack_i,
  input logic             nmi_o,
  input logic             irq_o,
  input logic [CTL_W-1:0] nmi_ctrl_o
);
  // R13
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_o, irq_o}));

  // R11
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o);

  // R7
  nmi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && !ack_i |=> nmi_o);

  // R7
  nmi_ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && ack_i |=> !nmi_o && !irq_o);

  // R12
  irq_ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i |=> !irq_o);

  // R2
  nmi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(nmi_ctrl_o[1] && nmi_ctrl_o[4]));

  // R5
  level_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) && !$past(nmi_ctrl_o[2]) && !$past(wr_en_i && !wr_sel_i)
      |-> !nmi_ctrl_o[4]);
endmodule

bind gated_nmi_intc gnmi_intc_chk #(.CTL_W(CTL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .ack_i      (ack_i),
  .nmi_o      (nmi_o),
  .irq_o      (irq_o),
  .nmi_ctrl_o (nmi_ctrl_o)
);

// File: tb/sim_gated_nmi_intc.sv
module sim_gated_nmi_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [NS-1:0] req = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic        nmi, irq;
  logic [7:0]  vec, ctrl;
  logic [15:0] rd_data;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_nmi_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(pin), .hw_req_i(req),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .ack_i(ack), .rd_idx_i(rd_idx), .nmi_o(nmi), .irq_o(irq),
    .act_vec_o(vec), .nmi_ctrl_o(ctrl), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_nmi(input logic [7:0] v);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = {8'h00, v};
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wr_hw(input int i, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 4'(i); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  function automatic logic [7:0] vec_of(input int i);
    return 8'(i * 13 + 5);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    check("R1 outputs in reset", {30'd0, nmi, irq}, 32'd0);
    check("R1 ctrl in reset", {24'd0, ctrl}, 32'd0);
    rst_n = 1'b1;
    tick();
    check("R1 outputs after reset", {30'd0, nmi, irq}, 32'd0);
    for (int i = 0; i < NS; i++) begin
      rd_idx = 4'(i); #1;
      check("R1 hw reg reset", {16'd0, rd_data}, 32'd0);
    end

    // R2/R5/R7 sweep of NMI control values
    for (int v = 0; v < 32; v++) begin
      logic take;
      take = v[1] & v[4];
      wr_nmi(8'(v));
      pin = 1'b1;
      tick(); tick();
      check("R2 nmi gating", {31'd0, nmi}, {31'd0, take});
      if (take) begin
        check("R5 ctrl after take", {24'd0, ctrl},
              {24'd0, v[2] ? 8'(v) : 8'(v & 8'hEF)});
        check("R7 nmi vector", {24'd0, vec}, 32'hFF);
        do_ack();
        check("R7 nmi dropped", {31'd0, nmi}, 32'd0);
      end else begin
        check("R2 ctrl unchanged", {24'd0, ctrl}, {24'd0, 8'(v)});
      end
      pin = 1'b0;
      tick(); tick();
    end

    // R3 pending lost when pin falls while disabled
    wr_nmi(8'h00);
    pin = 1'b1; tick(); tick();
    pin = 1'b0; tick(); tick();
    wr_nmi(8'h12); tick(); tick();
    check("R3 no stale nmi", {31'd0, nmi}, 32'd0);
    wr_nmi(8'h00);

    // R6 forced nmi
    wr_nmi(8'h08);
    wr_nmi(8'h12);
    tick();
    check("R6 forced nmi", {31'd0, nmi}, 32'd1);
    check("R6 level take disarms", {24'd0, ctrl}, 32'h02);
    do_ack();
    wr_nmi(8'h08);
    wr_nmi(8'h02);
    wr_nmi(8'h12); tick(); tick();
    check("R6 no force without enables", {31'd0, nmi}, 32'd0);

    // R5 collision: take and ctrl write on the same edge
    wr_nmi(8'h00);
    pin = 1'b1; tick(); tick();
    wr_nmi(8'h12);
    wr_nmi(8'h13);
    check("R5 collision nmi taken", {31'd0, nmi}, 32'd1);
    check("R5 collision write wins", {24'd0, ctrl}, 32'h13);
    do_ack();
    pin = 1'b0; tick();
    wr_nmi(8'h00);

    // R8/R9 force on hw source 5
    rd_idx = 4'd5;
    wr_hw(5, 16'h0955);
    check("R8 arm keeps pending", {16'd0, rd_data}, 32'h0855);
    tick();
    check("R8 arm no irq", {31'd0, irq}, 32'd0);
    wr_hw(5, 16'h0877);
    check("R9 fire sets pending", {16'd0, rd_data}, 32'h0977);
    tick();
    check("R9 forced irq", {23'd0, irq, vec}, 32'h177);
    do_ack();
    check("R12 ack clears pending", {16'd0, rd_data}, 32'h0877);
    wr_hw(5, 16'h0866); tick(); tick();
    check("R9 plain write", {16'd0, rd_data}, 32'h0866);
    check("R9 plain write no irq", {31'd0, irq}, 32'd0);

    // R10 request edges on disabled source 2, R8 keeps pending=1
    rd_idx = 4'd2;
    wr_hw(2, 16'h0022);
    req[2] = 1'b1; tick();
    check("R10 rise sets pending", {16'd0, rd_data}, 32'h0122);
    wr_hw(2, 16'h0133);
    check("R8 arm keeps pending set", {16'd0, rd_data}, 32'h0133);
    req[2] = 1'b0; tick();
    check("R10 fall clears pending", {16'd0, rd_data}, 32'h0033);
    wr_hw(2, 16'h0044);
    check("R9 armed write pends", {16'd0, rd_data}, 32'h0144);
    wr_hw(2, 16'h0000);
    check("R11 disabled not taken", {31'd0, irq}, 32'd0);

    // R11 single source sweep
    for (int i = 0; i < NS; i++) begin
      wr_hw(i, {8'h08, vec_of(i)});
      rd_idx = 4'(i);
      req[i] = 1'b1;
      tick(); tick();
      check("R11 single source", {23'd0, irq, vec}, {23'd0, 1'b1, vec_of(i)});
      do_ack();
      check("R12 pending cleared", {16'd0, rd_data}, {16'd0, 8'h08, vec_of(i)});
      req[i] = 1'b0;
      tick();
    end

    // R11/R13 priority over all pairs
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        req[i] = 1'b1; req[j] = 1'b1;
        tick(); tick();
        check("R11 lowest wins", {23'd0, irq, vec}, {23'd0, 1'b1, vec_of(i)});
        do_ack();
        tick();
        check("R13 next after ack", {23'd0, irq, vec}, {23'd0, 1'b1, vec_of(j)});
        do_ack();
        req[i] = 1'b0; req[j] = 1'b0;
        tick();
      end
    end

    // R4 NMI over hw, edge mode keeps enable-B
    wr_nmi(8'h16);
    req[3] = 1'b1; pin = 1'b1;
    tick(); tick();
    check("R4 nmi first", {30'd0, nmi, irq}, 32'd2);
    check("R5 edge mode keeps ctrl", {24'd0, ctrl}, 32'h16);
    do_ack();
    tick();
    check("R4 hw after nmi ack", {23'd0, irq, vec}, {23'd0, 1'b1, vec_of(3)});
    do_ack();
    req[3] = 1'b0; pin = 1'b0;
    tick();
    wr_nmi(8'h00);

    // R12 collision: ack and fresh request on the same edge
    req[4] = 1'b1; tick(); tick();
    check("R12 taken", {31'd0, irq}, 32'd1);
    req[4] = 1'b0; tick();
    check("R11 held after line drop", {31'd0, irq}, 32'd1);
    ack = 1'b1; req[4] = 1'b1;
    tick();
    ack = 1'b0;
    check("R12 dropped after ack", {31'd0, irq}, 32'd0);
    tick();
    check("R12 re-request kept", {23'd0, irq, vec}, {23'd0, 1'b1, vec_of(4)});
    do_ack();
    req[4] = 1'b0;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule